// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable synchronous SRAM with a small word array and a two-bit burst counter. Address, write data, chip enable, the two address strobes, the advance input and all write controls are sampled on the rising clock edge. A cycle either loads a fresh address, deselects the device, or continues the current burst, where the advance input may step the counter or hold it. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls in the same cycle. Continue cycles read or write the current burst word.

Three static mode inputs shape the timing. One selects flow-through or registered read data. One selects single-cycle or dual-cycle deselect of the outputs. One selects wrapping-increment or XOR burst order. The recommended tie-off values are registered output, single-cycle deselect and XOR order. Output enable and sleep act on the outputs without a clock. Sleep also freezes the block and blocks writes, and the stored words are kept. The bidirectional data pins are modelled as a read-data port plus a drive-enable flag.

Top module: `burst_sram`

## Requirements
- R1: A cycle with chip enable low and the processor strobe low loads addr_i and reads that word, even when write controls are asserted in that cycle.
- R2: A cycle with the processor strobe high and the controller strobe low loads addr_i when chip enable is low. It writes when a write control is active and reads otherwise. With chip enable high, the controller strobe is ignored and the cycle acts as a continue cycle.
- R3: Wrapping-increment order (ilv_i=0) accesses low address bits start+n mod 4 for burst step n. The upper address bits stay fixed.
- R4: XOR order (ilv_i=1) accesses low address bits start XOR n.
- R5: In a continue cycle of an active burst, step_n_i low advances the counter before the access. step_n_i high repeats the current word.
- R6: With bwe_n_i low, byte i (bits 9i+8..9i) is written only when bsel_n_i[i] is low. If no bsel_n_i bit is low, nothing is written.
- R7: gwe_n_i low writes every byte, whatever bwe_n_i and bsel_n_i are.
- R8: With pipe_i=0, read data is driven in the cycle right after the edge that captured the read.
- R9: With pipe_i=1, read data is driven one cycle later than with pipe_i=0, from an output register.
- R10: With dcd_i=0, a deselect turns the outputs off right after its own edge. This also suppresses a registered word landing on that edge. With dcd_i=1, the outputs keep driving for one more cycle and turn off after the next edge.
- R11: rdata_en_o requires oe_n_i low, acting without a clock. A write cycle turns the outputs off after its edge in flow-through mode.
- R12: sleep_i high forces the outputs off at once. It freezes all state and blocks writes. After wake-up, the block resumes where it stopped and the stored words are unchanged.
- R13: After reset, the outputs are off and no burst is active, so continue cycles access nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| addr_i | input | AW | Word address |
| wdata_i | input | NB*LW | Write data |
| ce_n_i | input | 1 | Chip enable, active low |
| pstrb_n_i | input | 1 | Processor-side address strobe, active low |
| cstrb_n_i | input | 1 | Controller-side address strobe, active low |
| step_n_i | input | 1 | Burst advance, active low |
| gwe_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bsel_n_i | input | NB | Per-byte write strobes, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous low-power request, active high |
| pipe_i | input | 1 | 1 = registered read data, 0 = flow-through |
| dcd_i | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle |
| ilv_i | input | 1 | 1 = XOR burst order, 0 = wrapping increment |
| rdata_o | output | NB*LW | Read data, zero when not driven |
| rdata_en_o | output | 1 | Data pins driven |

## Verification
The sharpest collision is a deselect captured on the same edge at which a registered read word is due to appear. Single-cycle deselect must win and blank that word. Dual-cycle deselect must let the word through and blank the following cycle. The bench provokes both by issuing a read and then a deselect on the next cycle, first with dcd_i low and then with dcd_i high, in registered mode, and in flow-through mode as well. It judges rdata_en_o and rdata_o one cycle at a time against the expected slot. The bench also tests a global write that coincides with a partial byte strobe pattern. It confirms that the whole word changed by reading it back with the next load.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [1:0] {
        CMD_CONT  = 2'd0,
        CMD_LOADP = 2'd1,
        CMD_LOADC = 2'd2,
        CMD_DESEL = 2'd3
    } cmd_e;

    // low two address bits for burst step n from the loaded start word
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] n,
                                             input logic       xor_order);
        return xor_order ? (start ^ n) : (start + n);
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int NB = 2
) (
    input  logic          ce_n_i,
    input  logic          pstrb_n_i,
    input  logic          cstrb_n_i,
    input  logic          gwe_n_i,
    input  logic          bwe_n_i,
    input  logic [NB-1:0] bsel_n_i,
    output cmd_e          cmd_o,
    output logic          wr_req_o,
    output logic [NB-1:0] mask_o
);

    always_comb begin
        if (!pstrb_n_i)
            cmd_o = ce_n_i ? CMD_DESEL : CMD_LOADP;
        else if (!cstrb_n_i && !ce_n_i)
            cmd_o = CMD_LOADC;
        else
            cmd_o = CMD_CONT;
    end

    // global write overrides the byte path
    always_comb begin
        if (!gwe_n_i)
            mask_o = '1;
        else if (!bwe_n_i)
            mask_o = ~bsel_n_i;
        else
            mask_o = '0;
        wr_req_o = |mask_o;
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int LW = 9,
    localparam int DW    = NB * LW,
    localparam int WORDS = 1 << AW
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [NB-1:0] mask_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem_q [WORDS];
    logic [DW-1:0] merged;

    for (genvar gb = 0; gb < NB; gb++) begin : g_lane
        assign merged[gb*LW +: LW] = mask_i[gb] ? wdata_i[gb*LW +: LW]
                                                : mem_q[waddr_i][gb*LW +: LW];
    end

    always_ff @(posedge clk_i) begin
        if (we_i)
            mem_q[waddr_i] <= merged;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sbsram_outq.sv
module sbsram_outq #(
    parameter int DW = 18
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          sleep_i,
    input  logic          oe_n_i,
    input  logic          pipe_i,
    input  logic          dcd_i,
    input  logic          rd_now_i,
    input  logic          rd_last_i,
    input  logic          dsel_now_i,
    input  logic          dsel_last_i,
    input  logic [DW-1:0] arr_data_i,
    output logic [DW-1:0] rdata_o,
    output logic          rdata_en_o
);

    typedef struct packed {
        logic          drive;
        logic [DW-1:0] dout;
    } oq_t;

    oq_t oq_d, oq_q;
    logic land, hold;

    always_comb begin
        oq_d = oq_q;
        // a read word reaches the pins on this edge
        land = pipe_i ? (rd_last_i && !(!dcd_i && dsel_now_i)) : rd_now_i;
        // dual-cycle deselect keeps the pins up for one more cycle
        hold = dcd_i && dsel_now_i && !dsel_last_i && oq_q.drive;
        if (!sleep_i) begin
            oq_d.drive = land || hold;
            if (rd_last_i)
                oq_d.dout = arr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            oq_q <= '0;
        end else begin
            oq_q <= oq_d;
        end
    end

    assign rdata_en_o = oq_q.drive && !oe_n_i && !sleep_i;
    assign rdata_o    = rdata_en_o ? (pipe_i ? oq_q.dout : arr_data_i) : '0;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import sbsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int LW = 9,
    localparam int DW = NB * LW
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          ce_n_i,
    input  logic          pstrb_n_i,
    input  logic          cstrb_n_i,
    input  logic          step_n_i,
    input  logic          gwe_n_i,
    input  logic          bwe_n_i,
    input  logic [NB-1:0] bsel_n_i,
    input  logic          oe_n_i,
    input  logic          sleep_i,
    input  logic          pipe_i,
    input  logic          dcd_i,
    input  logic          ilv_i,
    output logic [DW-1:0] rdata_o,
    output logic          rdata_en_o
);

    localparam int UW = AW - 2;

    typedef struct packed {
        logic [UW-1:0] upper;
        logic [1:0]    start;
        logic [1:0]    cnt;
        logic          active;
        logic          rd;
        logic          dsel;
        logic [AW-1:0] acc;
    } st_t;

    st_t st_d, st_q;

    cmd_e          cmd;
    logic          wr_req;
    logic [NB-1:0] mask;
    logic          rd_now, wr_now, dsel_now;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] arr_data;

    sbsram_decode #(.NB(NB)) u_decode (
        .ce_n_i    (ce_n_i),
        .pstrb_n_i (pstrb_n_i),
        .cstrb_n_i (cstrb_n_i),
        .gwe_n_i   (gwe_n_i),
        .bwe_n_i   (bwe_n_i),
        .bsel_n_i  (bsel_n_i),
        .cmd_o     (cmd),
        .wr_req_o  (wr_req),
        .mask_o    (mask)
    );

    always_comb begin
        st_d     = st_q;
        rd_now   = 1'b0;
        wr_now   = 1'b0;
        dsel_now = 1'b0;
        if (!sleep_i) begin
            unique case (cmd)
                CMD_LOADP: begin
                    st_d.upper  = addr_i[AW-1:2];
                    st_d.start  = addr_i[1:0];
                    st_d.cnt    = 2'd0;
                    st_d.active = 1'b1;
                    rd_now      = 1'b1;
                end
                CMD_LOADC: begin
                    st_d.upper  = addr_i[AW-1:2];
                    st_d.start  = addr_i[1:0];
                    st_d.cnt    = 2'd0;
                    st_d.active = 1'b1;
                    wr_now      = wr_req;
                    rd_now      = !wr_req;
                end
                CMD_DESEL: begin
                    st_d.active = 1'b0;
                    dsel_now    = 1'b1;
                end
                default: begin
                    if (st_q.active) begin
                        st_d.cnt = st_q.cnt + {1'b0, !step_n_i};
                        wr_now   = wr_req;
                        rd_now   = !wr_req;
                    end
                end
            endcase
            st_d.rd   = rd_now;
            st_d.dsel = dsel_now;
        end
        acc_addr = {st_d.upper, burst_low(st_d.start, st_d.cnt, ilv_i)};
        if (rd_now)
            st_d.acc = acc_addr;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sbsram_array #(.AW(AW), .NB(NB), .LW(LW)) u_array (
        .clk_i   (clk_i),
        .we_i    (wr_now),
        .mask_i  (mask),
        .waddr_i (acc_addr),
        .wdata_i (wdata_i),
        .raddr_i (st_q.acc),
        .rdata_o (arr_data)
    );

    sbsram_outq #(.DW(DW)) u_outq (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .sleep_i     (sleep_i),
        .oe_n_i      (oe_n_i),
        .pipe_i      (pipe_i),
        .dcd_i       (dcd_i),
        .rd_now_i    (rd_now),
        .rd_last_i   (st_q.rd),
        .dsel_now_i  (dsel_now),
        .dsel_last_i (st_q.dsel),
        .arr_data_i  (arr_data),
        .rdata_o     (rdata_o),
        .rdata_en_o  (rdata_en_o)
    );

    assert_ce_gates_cstrb_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ce_n_i && pstrb_n_i && !cstrb_n_i && !st_q.active && !sleep_i) |=> !st_q.active);

    assert_suspend_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cmd == CMD_CONT && st_q.active && step_n_i && !sleep_i) |=> $stable(st_q.cnt));

    assert_scd_off_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (dsel_now && !dcd_i) |=> !rdata_en_o);

    assert_flow_write_off_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wr_now && !pipe_i) |=> !rdata_en_o);

    assert_sleep_freeze_R12: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sleep_i |=> ($stable(st_q.cnt) && $stable(st_q.active) && $stable(st_q.acc)));

    assert_reset_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(rst_n_i) |-> (!rdata_en_o && !st_q.active));

endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;

    localparam int AW = 6;
    localparam int NB = 2;
    localparam int LW = 9;
    localparam int DW = NB * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ce_n = 1'b1, ps_n = 1'b1, cs_n = 1'b1, adv_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [NB-1:0] bs_n = '1;
    logic          oe_n = 1'b0, sleep = 1'b0;
    logic          pipe = 1'b0, dcd = 1'b0, ilv = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    burst_sram #(.AW(AW), .NB(NB), .LW(LW)) i_burst_sram (
        .clk_i(clk), .rst_n_i(rst_n), .addr_i(addr), .wdata_i(wdata),
        .ce_n_i(ce_n), .pstrb_n_i(ps_n), .cstrb_n_i(cs_n), .step_n_i(adv_n),
        .gwe_n_i(gw_n), .bwe_n_i(bwe_n), .bsel_n_i(bs_n), .oe_n_i(oe_n),
        .sleep_i(sleep), .pipe_i(pipe), .dcd_i(dcd), .ilv_i(ilv),
        .rdata_o(rdata), .rdata_en_o(rdata_en)
    );

    typedef struct packed {
        logic        ce_n, ps_n, cs_n, adv_n, gw_n, bwe_n;
        logic [1:0]  bs_n;
        logic [5:0]  addr;
        logic [17:0] wd;
        logic        pipe, dcd, ilv;
        logic        en;
        logic [17:0] d;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{0,1,0,1,0,1,2'b11,6'h08,18'h01111,0,0,0,0,18'h0,4'd11},     // R2 write load, R11 pins off
        '{0,1,1,0,0,1,2'b11,6'h00,18'h02222,0,0,0,0,18'h0,4'd5},      // R5 step write
        '{0,1,1,0,0,1,2'b11,6'h00,18'h03333,0,0,0,0,18'h0,4'd3},      // R3
        '{0,1,1,0,0,1,2'b11,6'h00,18'h04444,0,0,0,0,18'h0,4'd3},      // R3
        '{0,1,1,0,1,0,2'b10,6'h00,18'h3FFFF,0,0,0,0,18'h0,4'd6},      // R6 byte0 only, wraps to word 0
        '{0,0,1,1,1,1,2'b11,6'h0A,18'h0,0,0,1,1,18'h03333,4'd1},      // R1 load read
        '{0,1,1,0,1,1,2'b11,6'h00,18'h0,0,0,1,1,18'h04444,4'd4},      // R4 2^1
        '{0,1,1,0,1,1,2'b11,6'h00,18'h0,0,0,1,1,18'h011FF,4'd4},      // R4 2^2
        '{0,1,1,0,1,1,2'b11,6'h00,18'h0,0,0,1,1,18'h02222,4'd4},      // R4 2^3
        '{0,0,1,1,1,1,2'b11,6'h0A,18'h0,0,0,0,1,18'h03333,4'd8},      // R8 new address every cycle
        '{0,1,1,0,1,1,2'b11,6'h00,18'h0,0,0,0,1,18'h04444,4'd3},      // R3
        '{0,1,1,0,1,1,2'b11,6'h00,18'h0,0,0,0,1,18'h011FF,4'd3},      // R3 wrap
        '{0,1,1,1,1,1,2'b11,6'h00,18'h0,0,0,0,1,18'h011FF,4'd5},      // R5 hold
        '{0,1,1,0,1,1,2'b11,6'h00,18'h0,0,0,0,1,18'h02222,4'd3},      // R3
        '{0,1,1,1,1,0,2'b11,6'h00,18'h0,0,0,0,1,18'h02222,4'd6},      // R6 no strobe, no write
        '{0,1,1,1,0,0,2'b01,6'h00,18'h2AAAA,0,0,0,0,18'h0,4'd7},      // R7 global over bytes
        '{0,1,0,1,1,1,2'b11,6'h09,18'h0,0,0,0,1,18'h2AAAA,4'd7},      // R7 readback, R2 read load
        '{1,0,1,1,1,1,2'b11,6'h00,18'h0,0,0,0,0,18'h0,4'd10},         // R10 flow single deselect
        '{1,1,0,0,1,1,2'b11,6'h05,18'h0,0,0,0,0,18'h0,4'd2},          // R2 strobe ignored
        '{0,0,1,1,1,1,2'b11,6'h08,18'h0,1,0,0,0,18'h0,4'd9},          // R9 not yet
        '{0,1,1,0,1,1,2'b11,6'h00,18'h0,1,0,0,1,18'h011FF,4'd9},      // R9 word lands
        '{1,0,1,1,1,1,2'b11,6'h00,18'h0,1,0,0,0,18'h0,4'd10},         // R10 single deselect suppresses
        '{1,1,1,1,1,1,2'b11,6'h00,18'h0,1,0,0,0,18'h0,4'd10},         // R10
        '{0,0,1,1,1,1,2'b11,6'h0B,18'h0,1,1,0,0,18'h0,4'd9},          // R9
        '{1,0,1,1,1,1,2'b11,6'h00,18'h0,1,1,0,1,18'h04444,4'd10},     // R10 dual deselect lets it land
        '{1,1,1,1,1,1,2'b11,6'h00,18'h0,1,1,0,0,18'h0,4'd10},         // R10 off after second edge
        '{0,0,1,1,1,1,2'b11,6'h08,18'h0,0,1,0,1,18'h011FF,4'd8},      // R8
        '{1,0,1,1,1,1,2'b11,6'h00,18'h0,0,1,0,1,18'h011FF,4'd10},     // R10 dual deselect hold
        '{1,1,1,1,1,1,2'b11,6'h00,18'h0,0,1,0,0,18'h0,4'd10},         // R10
        '{0,0,1,1,0,1,2'b11,6'h0B,18'h0,0,1,0,1,18'h04444,4'd1}       // R1 write controls ignored
    };

    task automatic check(input string tag, input logic exp_en, input logic [DW-1:0] exp_d);
        n_chk++;
        if (rdata_en !== exp_en || rdata !== exp_d) begin
            n_bad++;
            $display("FAIL %s: en=%0b data=%05h, expected en=%0b data=%05h",
                     tag, rdata_en, rdata, exp_en, exp_d);
        end
    endtask

    task automatic set_idle();
        ce_n = 1'b1; ps_n = 1'b1; cs_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bs_n = '1; addr = '0; wdata = '0;
    endtask

    task automatic apply(input vec_t v);
        ce_n = v.ce_n; ps_n = v.ps_n; cs_n = v.cs_n; adv_n = v.adv_n;
        gw_n = v.gw_n; bwe_n = v.bwe_n; bs_n = v.bs_n; addr = v.addr;
        wdata = v.wd; pipe = v.pipe; dcd = v.dcd; ilv = v.ilv;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) tick();
        check("R13", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        check("R13", 1'b0, '0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            tick();
            check($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].en, VECS[i].d);
        end

        // R11: output enable acts without a clock edge
        @(negedge clk);
        set_idle();
        ce_n = 1'b0;  // hold the burst on word 0x0B with a repeat read
        oe_n = 1'b1;
        #0.5;
        check("R11", 1'b0, '0);
        oe_n = 1'b0;
        #0.5;
        check("R11", 1'b1, 18'h04444);

        // R12: sleep blanks at once, freezes state, blocks a write
        set_idle();
        sleep = 1'b1;
        #0.5;
        check("R12", 1'b0, '0);
        @(negedge clk);
        ce_n = 1'b0; cs_n = 1'b0; gw_n = 1'b0; addr = 6'h08; wdata = 18'h0;
        tick();
        check("R12", 1'b0, '0);
        @(negedge clk);
        set_idle();
        sleep = 1'b0;
        #0.5;
        check("R12", 1'b1, 18'h04444);
        @(negedge clk);
        ce_n = 1'b0; ps_n = 1'b0; addr = 6'h08;
        tick();
        check("R12", 1'b1, 18'h011FF);

        // R13: mid-run reset clears the pins and the burst
        @(negedge clk);
        set_idle();
        rst_n = 1'b0;
        tick();
        check("R13", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        adv_n = 1'b0;
        tick();
        check("R13", 1'b0, '0);
        tick();
        check("R13", 1'b0, '0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule